// File: doc/BRIEF.md
# Banked integer register file

This block holds the integer register state of a 32-bit processor core: eight data registers and eight address registers, addressed by a 4-bit index, plus a 16-bit status word. Index 15, the stack pointer, is banked across three physical registers: a user stack pointer, an interrupt stack pointer and a master stack pointer. The stored status word picks which one is live. Bit 13 is the supervisor flag and bit 12 is the master/interrupt select.

Two read ports and one write port serve the general registers. Read data is registered and comes one clock after the index is presented. A write to the same index in the same cycle is forwarded to the read. The status word has two write paths. One is a full-word path, which only supervisor code may use. The other is a byte path for the condition-code byte (bits 7:0), which works in any mode. A full-word write attempted from user mode is dropped and reported on a one-cycle violation flag. Instruction decode, the ALU and exception sequencing sit outside this block.

Top module: `rf_banked_gpr`

## Requirements
- R1: Indices 0 to 7 select data registers and 8 to 15 select address registers. A value written through the write port at index i is returned for index i on a read port one clock after that index is presented.
- R2: With status bit 13 clear (user mode), index 15 reads and writes the user stack pointer, and the other two stack pointers keep their values.
- R3: With status bit 13 set, index 15 maps to the interrupt stack pointer when status bit 12 is clear and to the master stack pointer when it is set. The unselected stack pointers keep their values.
- R4: A condition-code write updates status bits 7:0 only, in any mode. The new byte shows on `ccr_rdata` and on `sr_rdata` bits 7:0 from the next cycle.
- R5: In supervisor mode a full status write updates all 16 bits from the next cycle. In user mode `sr_rdata` shows bits 15:8 as zero.
- R6: A full status write in user mode leaves the whole status word unchanged and drives `priv_viol` high for exactly the following cycle.
- R7: The two read ports are independent: any two indices, equal or different, may be read in the same cycle.
- R8: When a read index equals the write index in the same cycle, the read returns the data being written (write-first), including at index 15.
- R9: Reset, synchronous and active high, clears all three stack pointers, sets the status word to 16'h2000 (supervisor, interrupt stack) and clears `priv_viol`.
- R10: A change of status bits 13 or 12 takes effect for stack-pointer accesses presented in the cycle after the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | General register write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| rd_a_idx | input | 4 | Read port A index |
| rd_b_idx | input | 4 | Read port B index |
| rd_a_data | output | 32 | Read port A data, one cycle after index |
| rd_b_data | output | 32 | Read port B data, one cycle after index |
| sr_wr_en | input | 1 | Full status word write strobe (supervisor only) |
| ccr_wr_en | input | 1 | Condition-code byte write strobe |
| sr_wdata | input | 16 | Status write data (bits 7:0 used by the byte path) |
| sr_rdata | output | 16 | Status word, high byte zeroed in user mode |
| ccr_rdata | output | 8 | Condition-code byte |
| sup_mode | output | 1 | Current supervisor flag (status bit 13) |
| priv_viol | output | 1 | One-cycle pulse after a refused user-mode status write |

## Verification
The assertions check on every cycle that a refused user-mode status write leaves the high byte untouched and raises the violation pulse, that a byte write lands only in the condition code, that a stack-pointer write touches only the selected bank, and that same-index reads are forwarded. The bench scenarios show what no single-cycle property captures: moving between the interrupt and master banks and back with their contents kept, the hiding of the high status byte after the drop to user mode, and the clearing of all three stack pointers by a second reset.

// File: rtl/rf_banked_pkg.sv
package rf_banked_pkg;
  localparam int SR_SUP_BIT = 13;
  localparam int SR_MST_BIT = 12;

  typedef enum logic [1:0] {
    SPB_USER = 2'd0,
    SPB_INTR = 2'd1,
    SPB_MSTR = 2'd2
  } sp_bank_e;

  function automatic sp_bank_e sp_pick(input logic sup, input logic mst);
    if (!sup) return SPB_USER;
    if (mst)  return SPB_MSTR;
    return SPB_INTR;
  endfunction
endpackage

// File: rtl/rf_gpr_ram.sv
module rf_gpr_ram #(
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int NRD = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered reads, write-first on an address match
  always_ff @(posedge clk) begin
    for (int p = 0; p < NRD; p++) begin
      if (we && waddr == raddr[p]) rdata[p] <= wdata;
      else                         rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank
  import rf_banked_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  sp_bank_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int NBANK = 3;

  logic [NBANK-1:0][DW-1:0] sp_flat;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                          q <= '0;
        else if (we && sel == sp_bank_e'(b)) q <= wdata;
      end
      assign sp_flat[b] = q;
    end
  endgenerate

  always_comb begin
    case (sel)
      SPB_INTR: rdata = sp_flat[1];
      SPB_MSTR: rdata = sp_flat[2];
      default:  rdata = sp_flat[0];
    endcase
  end

  assert_user_bank_only_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SPB_USER) |=> (sp_flat[0] == $past(wdata)) &&
      (sp_flat[1] == $past(sp_flat[1])) && (sp_flat[2] == $past(sp_flat[2])));

  assert_master_bank_only_R3: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SPB_MSTR) |=> (sp_flat[2] == $past(wdata)) &&
      (sp_flat[0] == $past(sp_flat[0])) && (sp_flat[1] == $past(sp_flat[1])));

  assert_intr_bank_only_R3: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SPB_INTR) |=> (sp_flat[1] == $past(wdata)) &&
      (sp_flat[0] == $past(sp_flat[0])) && (sp_flat[2] == $past(sp_flat[2])));
endmodule

// File: rtl/rf_status.sv
module rf_status
  import rf_banked_pkg::*;
#(
  parameter int          SRW       = 16,
  parameter int          CCW       = 8,
  parameter logic [15:0] RESET_VAL = 16'h2000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sr_we,
  input  logic           ccr_we,
  input  logic [SRW-1:0] wdata,
  output logic [SRW-1:0] sr_q,
  output logic           priv_viol
);
  logic sup;
  assign sup = sr_q[SR_SUP_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= RESET_VAL[SRW-1:0];
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= sr_we && !sup;
      if (sr_we && sup)  sr_q <= wdata;
      else if (ccr_we)   sr_q[CCW-1:0] <= wdata[CCW-1:0];
    end
  end

  assert_user_sr_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (sr_we && !sup) |=> (sr_q[SRW-1:CCW] == $past(sr_q[SRW-1:CCW])) && priv_viol);

  assert_viol_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> $past(sr_we && !sup));

  assert_ccr_byte_only_R4: assert property (@(posedge clk) disable iff (rst)
    (ccr_we && !(sr_we && sup)) |=>
      (sr_q[CCW-1:0] == $past(wdata[CCW-1:0])) &&
      (sr_q[SRW-1:CCW] == $past(sr_q[SRW-1:CCW])));

  assert_sup_full_write_R5: assert property (@(posedge clk) disable iff (rst)
    (sr_we && sup) |=> sr_q == $past(wdata));
endmodule

// File: rtl/rf_banked_gpr.sv
module rf_banked_gpr
  import rf_banked_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          IW       = 4,
  parameter int          SRW      = 16,
  parameter int          CCW      = 8,
  parameter logic [15:0] SR_RESET = 16'h2000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [IW-1:0]  rd_a_idx,
  input  logic [IW-1:0]  rd_b_idx,
  output logic [DW-1:0]  rd_a_data,
  output logic [DW-1:0]  rd_b_data,
  input  logic           sr_wr_en,
  input  logic           ccr_wr_en,
  input  logic [SRW-1:0] sr_wdata,
  output logic [SRW-1:0] sr_rdata,
  output logic [CCW-1:0] ccr_rdata,
  output logic           sup_mode,
  output logic           priv_viol
);
  localparam int          NRD    = 2;
  localparam logic [IW-1:0] SP_IDX = IW'((1 << IW) - 1);

  logic [SRW-1:0]          sr_q;
  sp_bank_e                sp_sel;
  logic [NRD-1:0][IW-1:0]  rd_idx;
  logic [NRD-1:0][DW-1:0]  ram_q;
  logic [NRD-1:0][DW-1:0]  rd_out;
  logic [NRD-1:0][DW-1:0]  sp_hold_q;
  logic [NRD-1:0]          is_sp_q;
  logic [DW-1:0]           sp_rd;
  logic                    wr_is_sp;

  assign rd_idx   = {rd_b_idx, rd_a_idx};
  assign sp_sel   = sp_pick(sr_q[SR_SUP_BIT], sr_q[SR_MST_BIT]);
  assign wr_is_sp = wr_idx == SP_IDX;

  rf_status #(.SRW(SRW), .CCW(CCW), .RESET_VAL(SR_RESET)) u_status (
    .clk(clk), .rst(rst), .sr_we(sr_wr_en), .ccr_we(ccr_wr_en),
    .wdata(sr_wdata), .sr_q(sr_q), .priv_viol(priv_viol)
  );

  rf_gpr_ram #(.DW(DW), .AW(IW), .NRD(NRD)) u_ram (
    .clk(clk), .we(wr_en && !wr_is_sp), .waddr(wr_idx), .wdata(wr_data),
    .raddr(rd_idx), .rdata(ram_q)
  );

  rf_sp_bank #(.DW(DW)) u_sp (
    .clk(clk), .rst(rst), .we(wr_en && wr_is_sp), .sel(sp_sel),
    .wdata(wr_data), .rdata(sp_rd)
  );

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_port
      always_ff @(posedge clk) begin
        is_sp_q[p] <= rd_idx[p] == SP_IDX;
        if (wr_en && wr_is_sp) sp_hold_q[p] <= wr_data;
        else                   sp_hold_q[p] <= sp_rd;
      end
      assign rd_out[p] = is_sp_q[p] ? sp_hold_q[p] : ram_q[p];
    end
  endgenerate

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
  assign sup_mode  = sr_q[SR_SUP_BIT];
  assign ccr_rdata = sr_q[CCW-1:0];
  assign sr_rdata  = sup_mode ? sr_q : {{(SRW-CCW){1'b0}}, sr_q[CCW-1:0]};

  assert_bypass_a_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_a_idx == wr_idx) |=> rd_a_data == $past(wr_data));

  assert_bypass_b_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_b_idx == wr_idx) |=> rd_b_data == $past(wr_data));

  assert_user_high_hidden_R5: assert property (@(posedge clk) disable iff (rst)
    !sup_mode |-> sr_rdata[SRW-1:CCW] == '0);
endmodule

// File: tb/test_rf_banked_gpr.sv
module test_rf_banked_gpr;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [3:0]  rd_a_idx, rd_b_idx;
  logic [31:0] rd_a_data, rd_b_data;
  logic        sr_wr_en, ccr_wr_en;
  logic [15:0] sr_wdata, sr_rdata;
  logic [7:0]  ccr_rdata;
  logic        sup_mode, priv_viol;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  rf_banked_gpr i_rf_banked_gpr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_a_data(rd_a_data),
    .rd_b_data(rd_b_data), .sr_wr_en(sr_wr_en), .ccr_wr_en(ccr_wr_en),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .ccr_rdata(ccr_rdata),
    .sup_mode(sup_mode), .priv_viol(priv_viol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, input logic [3:0] b);
    rd_a_idx = a; rd_b_idx = b;
    tick();
  endtask

  task automatic sr_write(input logic [15:0] v);
    sr_wr_en = 1'b1; sr_wdata = v;
    tick();
    sr_wr_en = 1'b0;
  endtask

  task automatic ccr_write(input logic [7:0] v);
    ccr_wr_en = 1'b1; sr_wdata = {8'hEE, v};
    tick();
    ccr_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  function automatic logic [31:0] gval(input int i);
    return 32'h1357_0000 ^ (i * 32'h0001_0203);
  endfunction

  task automatic t_reset_state();
    check("R9 sr after reset", {16'h0, sr_rdata}, 32'h2000);
    check("R9 viol after reset", {31'h0, priv_viol}, 32'h0);
    check("R9 sup after reset", {31'h0, sup_mode}, 32'h1);
    reg_read(4'd15, 4'd15);
    check("R9 isp cleared", rd_a_data, 32'h0);
  endtask

  task automatic t_gpr();
    for (int i = 0; i < 15; i++) reg_write(4'(i), gval(i));
    for (int i = 0; i < 15; i++) begin
      reg_read(4'(i), 4'(14 - i));
      check("R1 port a data", rd_a_data, gval(i));
      check("R7 port b data", rd_b_data, gval(14 - i));
    end
    reg_read(4'd9, 4'd9);
    check("R7 same index a", rd_a_data, gval(9));
    check("R7 same index b", rd_b_data, gval(9));
  endtask

  task automatic t_bypass();
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
    rd_a_idx = 4'd3; rd_b_idx = 4'd4;
    tick();
    wr_en = 1'b0;
    check("R8 bypass gpr", rd_a_data, 32'hDEAD_0003);
    check("R8 other port unaffected", rd_b_data, gval(4));
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_1500;
    rd_a_idx = 4'd2; rd_b_idx = 4'd15;
    tick();
    wr_en = 1'b0;
    check("R8 bypass stack pointer", rd_b_data, 32'h0000_1500);
  endtask

  task automatic t_banks();
    reg_write(4'd15, 32'h1111_AAAA);
    sr_write(16'h3000);
    reg_read(4'd15, 4'd0);
    check("R10 master bank live, R9 msp cleared", rd_a_data, 32'h0);
    reg_write(4'd15, 32'h2222_BBBB);
    reg_read(4'd15, 4'd0);
    check("R3 master write", rd_a_data, 32'h2222_BBBB);
    sr_write(16'h2000);
    reg_read(4'd15, 4'd0);
    check("R3 interrupt bank kept", rd_a_data, 32'h1111_AAAA);
    sr_write(16'h3000);
    reg_read(4'd15, 4'd0);
    check("R3 master bank kept", rd_a_data, 32'h2222_BBBB);
  endtask

  task automatic t_status_sup();
    sr_write(16'h2704);
    check("R5 full write sup", {16'h0, sr_rdata}, 32'h2704);
    check("R5 no viol in sup", {31'h0, priv_viol}, 32'h0);
    ccr_write(8'h1F);
    check("R4 ccr byte", {24'h0, ccr_rdata}, 32'h1F);
    check("R4 high byte kept", {16'h0, sr_rdata}, 32'h271F);
  endtask

  task automatic t_user();
    sr_write(16'h0704);
    check("R5 user high hidden", {16'h0, sr_rdata}, 32'h0004);
    check("R2 mode user", {31'h0, sup_mode}, 32'h0);
    reg_read(4'd15, 4'd15);
    check("R2 usp initially zero", rd_a_data, 32'h0);
    reg_write(4'd15, 32'h3333_CCCC);
    reg_read(4'd15, 4'd1);
    check("R2 usp write", rd_a_data, 32'h3333_CCCC);
    sr_write(16'h3700);
    check("R6 viol pulse", {31'h0, priv_viol}, 32'h1);
    check("R6 still user", {31'h0, sup_mode}, 32'h0);
    check("R6 low byte kept", {24'h0, ccr_rdata}, 32'h04);
    tick();
    check("R6 viol one cycle", {31'h0, priv_viol}, 32'h0);
    ccr_write(8'h11);
    check("R4 ccr in user", {24'h0, ccr_rdata}, 32'h11);
  endtask

  task automatic t_rereset();
    do_reset();
    check("R9 sr reset again", {16'h0, sr_rdata}, 32'h2000);
    reg_read(4'd15, 4'd15);
    check("R9 isp cleared again", rd_b_data, 32'h0);
    sr_write(16'h3000);
    reg_read(4'd15, 4'd15);
    check("R9 msp cleared again", rd_a_data, 32'h0);
    sr_write(16'h0000);
    reg_read(4'd15, 4'd15);
    check("R9 usp cleared again", rd_a_data, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    sr_wr_en = 1'b0; ccr_wr_en = 1'b0; sr_wdata = '0;
    do_reset();
    t_reset_state();
    t_gpr();
    t_bypass();
    t_banks();
    t_status_sup();
    t_user();
    t_rereset();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule